// File: doc/BRIEF.md
# Stack Frame Enter/Leave Sequencer

This block carries out the two stack-frame instructions of a 64-bit CPU datapath as multi-cycle memory sequences. A one-cycle `start` launches an operation. With `op_leave` = 0 it performs procedure entry: it saves the caller's frame pointer, copies a display of outer frame pointers for nested procedures, links the new frame, reserves local space and probes the final stack slot. With `op_leave` = 1 it performs procedure exit: it restores the caller's frame pointer from the current frame.

All memory traffic goes through one registered qword port, with one access in flight at a time. An access is complete on the clock edge where `mem_rdy` is high. The updated stack and frame pointers appear on `sp_out`/`fp_out` together with a one-cycle `done`. They are returned only after the last memory step. A memory error leaves the pointers as they were and reports `fault`.

Top module: `frame_seq`

## Requirements
- R1: Entry uses only the low 5 bits of `nest_level`: L = `nest_level` & 0x1F. For example, 8'h21 behaves as level 1 and 8'hE0 behaves as level 0.
- R2: Entry first writes `fp_in` to address `sp_in`-8. That address becomes the new frame pointer F.
- R3: For L>=2, entry performs L-1 copy pairs, with k running from 1 to L-1. Each pair reads the qword at `fp_in`-8k and then writes it to the next lower stack slot: `sp_in`-8(k+1).
- R4: For L>=1, after the copies, F is written once more at the next lower slot. For L=0 there are no copies and no such write.
- R5: The zero-extended `frame_size` is then subtracted to give S. Entry ends with a read of address S, followed by a write of the same value back to S.
- R6: A successful entry gives `fp_out`=F and `sp_out`=S. `done` is high for exactly one cycle, and `fault` is 0.
- R7: Exit reads the qword Q at `fp_in`. It then returns `sp_out`=`fp_in`+8 and `fp_out`=Q. This is its only access.
- R8: A request (`mem_rd` or `mem_wr`, never both) keeps its address, data and direction until the edge where `mem_rdy` is high. At most one request is outstanding.
- R9: A `start` that arrives while an operation is in progress has no effect. It adds no access and no extra `done`.
- R10: If `mem_err` is high when `mem_rdy` completes an access, the operation stops. For that access, a write is not counted as done. `done` and `fault` pulse together, `sp_out`=`sp_in` and `fp_out`=`fp_in` as given at start, and no further access is issued.
- R11: All pointer arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op_leave | input | 1 | 0 = procedure entry, 1 = procedure exit |
| frame_size | input | 16 | Local-space byte count for entry |
| nest_level | input | 8 | Nesting level for entry (low 5 bits used) |
| sp_in | input | 64 | Current stack pointer |
| fp_in | input | 64 | Current frame pointer |
| mem_addr | output | 64 | Qword byte address |
| mem_wdata | output | 64 | Write data |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_rdata | input | 64 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Completes the pending access |
| mem_err | input | 1 | Access failed, sampled with mem_rdy |
| sp_out | output | 64 | Resulting stack pointer |
| fp_out | output | 64 | Resulting frame pointer |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Abort indication, pulses with done |

## Verification
The bench builds the block with its defaults: 64-bit pointers, a 16-bit size and a 5-bit effective level. At these values the full 31-level display copy is reachable, as are the largest frame size and wraparound at both ends of the address space. The memory model answers with 0 to 3 wait cycles, so requests are held over several edges. Errors are injected at chosen steps of an entry and on an exit.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_FP,
    ST_COPY_RD,
    ST_COPY_WR,
    ST_LINK_WR,
    ST_PROBE_RD,
    ST_PROBE_WR,
    ST_EXIT_RD
  } seq_state_t;

endpackage

// File: rtl/frame_seq_memport.sv
module frame_seq_memport #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss,
  input  logic          iss_wr,
  input  logic [DW-1:0] iss_addr,
  input  logic [DW-1:0] iss_data,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  input  logic          mem_err,
  output logic          rsp_vld,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err
);

  logic busy;
  assign busy = mem_rd | mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      rsp_vld   <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_vld <= 1'b0;
      if (busy && mem_rdy) begin
        mem_wr   <= 1'b0;
        mem_rd   <= 1'b0;
        rsp_vld  <= 1'b1;
        rsp_data <= mem_rdata;
        rsp_err  <= mem_err;
      end else if (iss) begin
        mem_wr    <= iss_wr;
        mem_rd    <= ~iss_wr;
        mem_addr  <= iss_addr;
        mem_wdata <= iss_data;
      end
    end
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && !mem_rdy |=> busy && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wr)); // R8

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    iss |-> !busy && !rsp_vld); // R8

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
#(
  parameter int DW       = 64,
  parameter int SZ_W     = 16,
  parameter int LV_W     = 8,
  parameter int LVL_BITS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            op_leave,
  input  logic [SZ_W-1:0] frame_size,
  input  logic [LV_W-1:0] nest_level,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   fp_in,
  output logic            iss,
  output logic            iss_wr,
  output logic [DW-1:0]   iss_addr,
  output logic [DW-1:0]   iss_data,
  input  logic            rsp_vld,
  input  logic [DW-1:0]   rsp_data,
  input  logic            rsp_err,
  output logic [DW-1:0]   sp_out,
  output logic [DW-1:0]   fp_out,
  output logic            done,
  output logic            fault
);

  localparam int            WB   = DW / 8;
  localparam logic [DW-1:0] STEP = DW'(WB);

  seq_state_t          st;
  logic                pend;
  logic [DW-1:0]       old_sp, old_fp;
  logic [DW-1:0]       tsp, tbp, fp_new, dat;
  logic [DW-1:0]       size_ext;
  logic [SZ_W-1:0]     size_q;
  logic [LVL_BITS-1:0] lvl_q, cnt;
  logic                mem_st;

  generate
    if (LV_W > LVL_BITS) begin : g_lvl_trim
      logic unused_lvl_hi;
      assign unused_lvl_hi = ^nest_level[LV_W-1:LVL_BITS];
    end
  endgenerate

  assign size_ext = {{(DW-SZ_W){1'b0}}, size_q};

  always_comb begin
    mem_st   = 1'b1;
    iss_wr   = 1'b0;
    iss_addr = tsp;
    iss_data = dat;
    case (st)
      ST_SAVE_FP:  begin iss_wr = 1'b1; iss_data = old_fp; end
      ST_COPY_RD:  iss_addr = tbp;
      ST_COPY_WR:  iss_wr = 1'b1;
      ST_LINK_WR:  begin iss_wr = 1'b1; iss_data = fp_new; end
      ST_PROBE_RD: iss_wr = 1'b0;
      ST_PROBE_WR: iss_wr = 1'b1;
      ST_EXIT_RD:  iss_addr = old_fp;
      default:     mem_st = 1'b0;
    endcase
  end

  assign iss = mem_st & ~pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pend   <= 1'b0;
      old_sp <= '0;
      old_fp <= '0;
      tsp    <= '0;
      tbp    <= '0;
      fp_new <= '0;
      dat    <= '0;
      size_q <= '0;
      lvl_q  <= '0;
      cnt    <= '0;
      sp_out <= '0;
      fp_out <= '0;
      done   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (iss) pend <= 1'b1;
      if (st == ST_IDLE) begin
        if (start) begin
          old_sp <= sp_in;
          old_fp <= fp_in;
          size_q <= frame_size;
          lvl_q  <= nest_level[LVL_BITS-1:0];
          tsp    <= sp_in - STEP;
          tbp    <= fp_in;
          st     <= op_leave ? ST_EXIT_RD : ST_SAVE_FP;
        end
      end else if (rsp_vld) begin
        pend <= 1'b0;
        if (rsp_err) begin
          st     <= ST_IDLE;
          done   <= 1'b1;
          fault  <= 1'b1;
          sp_out <= old_sp;
          fp_out <= old_fp;
        end else begin
          case (st)
            ST_SAVE_FP: begin
              fp_new <= tsp;
              if (lvl_q == '0) begin
                tsp <= tsp - size_ext;
                st  <= ST_PROBE_RD;
              end else if (lvl_q == LVL_BITS'(1)) begin
                tsp <= tsp - STEP;
                st  <= ST_LINK_WR;
              end else begin
                tbp <= tbp - STEP;
                cnt <= lvl_q - LVL_BITS'(1);
                st  <= ST_COPY_RD;
              end
            end
            ST_COPY_RD: begin
              dat <= rsp_data;
              tsp <= tsp - STEP;
              st  <= ST_COPY_WR;
            end
            ST_COPY_WR: begin
              cnt <= cnt - LVL_BITS'(1);
              if (cnt == LVL_BITS'(1)) begin
                tsp <= tsp - STEP;
                st  <= ST_LINK_WR;
              end else begin
                tbp <= tbp - STEP;
                st  <= ST_COPY_RD;
              end
            end
            ST_LINK_WR: begin
              tsp <= tsp - size_ext;
              st  <= ST_PROBE_RD;
            end
            ST_PROBE_RD: begin
              dat <= rsp_data;
              st  <= ST_PROBE_WR;
            end
            ST_PROBE_WR: begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              sp_out <= tsp;
              fp_out <= fp_new;
            end
            ST_EXIT_RD: begin
              st     <= ST_IDLE;
              done   <= 1'b1;
              sp_out <= old_fp + STEP;
              fp_out <= rsp_data;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> done); // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) && start |=> $stable(old_sp) && $stable(old_fp)); // R9

  AST_NO_ISSUE_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    rsp_vld && rsp_err |=> st == ST_IDLE); // R10

endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int DW       = 64,
  parameter int SZ_W     = 16,
  parameter int LV_W     = 8,
  parameter int LVL_BITS = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            op_leave,
  input  logic [SZ_W-1:0] frame_size,
  input  logic [LV_W-1:0] nest_level,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   fp_in,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_wr,
  output logic            mem_rd,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rdy,
  input  logic            mem_err,
  output logic [DW-1:0]   sp_out,
  output logic [DW-1:0]   fp_out,
  output logic            done,
  output logic            fault
);

  logic          iss, iss_wr, rsp_vld, rsp_err;
  logic [DW-1:0] iss_addr, iss_data, rsp_data;

  frame_seq_ctrl #(
    .DW(DW), .SZ_W(SZ_W), .LV_W(LV_W), .LVL_BITS(LVL_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_leave(op_leave),
    .frame_size(frame_size), .nest_level(nest_level),
    .sp_in(sp_in), .fp_in(fp_in),
    .iss(iss), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_data(iss_data),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .sp_out(sp_out), .fp_out(fp_out), .done(done), .fault(fault)
  );

  frame_seq_memport #(.DW(DW)) u_port (
    .clk(clk), .rst(rst),
    .iss(iss), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_data(iss_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_err(mem_err),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

endmodule

// File: tb/sim_frame_seq.sv
module sim_frame_seq;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic        wr;
    logic [63:0] addr;
    logic [63:0] data;
  } tx_t;

  typedef struct packed {
    logic [63:0] sp;
    logic [63:0] fp;
    logic        flt;
  } res_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_leave = 1'b0;
  logic [15:0] frame_size = '0;
  logic [7:0]  nest_level = '0;
  logic [63:0] sp_in = '0, fp_in = '0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_wr, mem_rd, mem_rdy, mem_err;
  logic [63:0] sp_out, fp_out;
  logic        done, fault;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R6";
  int mem_lat = 0;
  int err_step = -1;
  int step_i = 0;
  int done_cnt = 0;

  tx_t  txq[$];
  res_t rq[$];
  logic [63:0] dut_mem [logic [63:0]];
  logic [63:0] exp_mem [logic [63:0]];

  always #(CLK_P/2) clk = ~clk;

  frame_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op_leave(op_leave),
    .frame_size(frame_size), .nest_level(nest_level),
    .sp_in(sp_in), .fp_in(fp_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_err(mem_err),
    .sp_out(sp_out), .fp_out(fp_out), .done(done), .fault(fault)
  );

  function automatic logic [63:0] pattern(input logic [63:0] a);
    return a ^ 64'h5A5A_0000_C3C3_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder and transaction monitor (scoreboard consumer)
  initial begin
    bit          inreq;
    int          wcnt;
    logic [63:0] haddr, rv;
    tx_t         e;
    mem_rdy = 1'b0; mem_err = 1'b0; mem_rdata = '0; inreq = 0; wcnt = 0; haddr = '0;
    forever begin
      @(negedge clk);
      if (mem_rdy) begin
        mem_rdy = 1'b0; mem_err = 1'b0; inreq = 0;
      end else if (mem_rd || mem_wr) begin
        if (!inreq) begin inreq = 1; wcnt = mem_lat; haddr = mem_addr; end
        if (wcnt == 0) begin
          chk(!(mem_rd && mem_wr) && (haddr == mem_addr), "R8", "request held, rd/wr exclusive",
              mem_addr, haddr);
          rv = dut_mem.exists(mem_addr) ? dut_mem[mem_addr] : pattern(mem_addr);
          if (txq.size() == 0) begin
            chk(0, cur_tag, "unexpected memory access", mem_addr, '0);
          end else begin
            e = txq.pop_front();
            chk(e.wr == mem_wr, cur_tag, "access direction", 64'(mem_wr), 64'(e.wr));
            chk(e.addr == mem_addr, cur_tag, "access address", mem_addr, e.addr);
            if (mem_wr) chk(e.data == mem_wdata, cur_tag, "write data", mem_wdata, e.data);
            else        chk(e.data == rv, cur_tag, "read data seen", rv, e.data);
          end
          mem_rdata = rv;
          mem_err = (step_i == err_step);
          if (mem_wr && !mem_err) dut_mem[mem_addr] = mem_wdata;
          step_i++;
          mem_rdy = 1'b1;
        end else begin
          wcnt--;
        end
      end
    end
  end

  // result monitor
  initial begin
    bit   prev;
    res_t r;
    prev = 0;
    forever begin
      @(negedge clk);
      if (prev) chk(!done, "R6", "done lasts one cycle", 64'(done), 64'd0);
      if (done) begin
        done_cnt++;
        if (rq.size() == 0) begin
          chk(0, cur_tag, "unexpected done", sp_out, '0);
        end else begin
          r = rq.pop_front();
          chk(sp_out == r.sp, cur_tag, "sp_out", sp_out, r.sp);
          chk(fp_out == r.fp, cur_tag, "fp_out", fp_out, r.fp);
          chk(fault == r.flt, cur_tag, "fault", 64'(fault), 64'(r.flt));
        end
      end
      prev = done;
    end
  end

  // expectation builders (scoreboard producer)
  int  ex_n;
  bit  ex_stop;

  function automatic logic [63:0] ex_peek(input logic [63:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : pattern(a);
  endfunction

  function automatic void ex_w(input logic [63:0] a, input logic [63:0] d);
    tx_t t;
    if (ex_stop) return;
    t.wr = 1'b1; t.addr = a; t.data = d;
    txq.push_back(t);
    if (ex_n == err_step) ex_stop = 1;
    else exp_mem[a] = d;
    ex_n++;
  endfunction

  function automatic logic [63:0] ex_r(input logic [63:0] a);
    tx_t t;
    if (ex_stop) return '0;
    t.wr = 1'b0; t.addr = a; t.data = ex_peek(a);
    txq.push_back(t);
    if (ex_n == err_step) ex_stop = 1;
    ex_n++;
    return t.data;
  endfunction

  task automatic run_op(input bit lv, input logic [63:0] sp, input logic [63:0] fp,
                        input logic [15:0] sz, input logic [7:0] lvl, input int lat,
                        input int errs, input bit poke, input string tag);
    logic [63:0] t, tb, frame, v;
    int          l, d0, guard;
    res_t        r;
    cur_tag = tag; mem_lat = lat; err_step = errs; step_i = 0;
    ex_n = 0; ex_stop = 0;
    if (!lv) begin
      l = int'(lvl & 8'h1F);
      t = sp - 64'd8;
      ex_w(t, fp);
      frame = t; tb = fp;
      if (l > 0) begin
        for (int k = 1; k < l; k++) begin
          tb = tb - 64'd8;
          v = ex_r(tb);
          t = t - 64'd8;
          ex_w(t, v);
        end
        t = t - 64'd8;
        ex_w(t, frame);
      end
      t = t - {48'd0, sz};
      v = ex_r(t);
      ex_w(t, v);
      r.sp = t; r.fp = frame;
    end else begin
      v = ex_r(fp);
      r.sp = fp + 64'd8; r.fp = v;
    end
    r.flt = ex_stop;
    if (ex_stop) begin r.sp = sp; r.fp = fp; end
    rq.push_back(r);
    d0 = done_cnt;
    @(negedge clk);
    op_leave = lv; sp_in = sp; fp_in = fp; frame_size = sz; nest_level = lvl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      op_leave = ~lv; sp_in = 64'hDEAD_0000; fp_in = 64'hBEEF_0000; nest_level = 8'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 5000) begin @(negedge clk); guard++; end
    chk(done_cnt != d0, tag, "operation completed", 64'(guard), 64'd0);
    repeat (12) @(negedge clk);
    chk(txq.size() == 0 && rq.size() == 0 && done_cnt == d0 + 1, tag,
        "no leftover or extra activity", 64'(txq.size() + rq.size()), 64'd0);
    txq.delete(); rq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, cur_tag, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fault && !mem_rd && !mem_wr && sp_out == '0 && fp_out == '0,
        "R6", "reset state", {60'd0, done, fault, mem_rd, mem_wr}, 64'd0);
    // R2 R5 R6: level 0, only save, size subtract, probe
    run_op(0, 64'h0000_0000_0001_0000, 64'h0000_0000_0002_0000, 16'h0020, 8'd0, 0, -1, 0, "R5");
    // R3 R4 R8: level 3 with wait states
    run_op(0, 64'h0000_0000_0004_0000, 64'h0000_0000_0008_0000, 16'h0100, 8'd3, 2, -1, 0, "R3");
    // R1: 8'h21 masks to level 1
    run_op(0, 64'h0000_0000_0005_0000, 64'h0000_0000_0009_0000, 16'h0008, 8'h21, 1, -1, 0, "R1");
    // R1: 8'hE0 masks to level 0
    run_op(0, 64'h0000_0000_0006_0000, 64'h0000_0000_000A_0000, 16'h0010, 8'hE0, 0, -1, 0, "R1");
    // R1 R3 R5: level 31, largest frame size (zero-extended)
    run_op(0, 64'h0000_0000_0010_0000, 64'h0000_0000_0020_0000, 16'hFFFF, 8'hFF, 3, -1, 0, "R3");
    // R4 R5: size 0, probe lands on linked frame pointer
    run_op(0, 64'h0000_0000_0000_2000, 64'h0000_0000_0000_3000, 16'h0000, 8'd2, 1, -1, 0, "R4");
    // R7: exit reading back a saved value
    run_op(1, 64'h0, 64'h0000_0000_0000_1FF8, 16'h0, 8'd0, 2, -1, 0, "R7");
    // R11: wrap below zero on entry, above all-ones on exit
    run_op(0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0040, 16'h0030, 8'd0, 0, -1, 0, "R11");
    run_op(1, 64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0, 8'd0, 0, -1, 0, "R11");
    // R9: start while busy ignored
    run_op(0, 64'h0000_0000_0030_0000, 64'h0000_0000_0040_0000, 16'h0040, 8'd3, 1, -1, 1, "R9");
    // R10: error on a copy write, then on an exit read
    run_op(0, 64'h0000_0000_0050_0000, 64'h0000_0000_0060_0000, 16'h0040, 8'd3, 1, 2, 0, "R10");
    run_op(1, 64'h0, 64'h0000_0000_0070_0000, 16'h0, 8'd0, 0, 0, 0, "R10");
    // R10: error on the final probe write
    run_op(0, 64'h0000_0000_0080_0000, 64'h0000_0000_0090_0000, 16'h0020, 8'd0, 0, 2, 0, "R10");
    // R2: recovery after fault, normal entry
    run_op(0, 64'h0000_0000_00A0_0000, 64'h0000_0000_00B0_0000, 16'h0018, 8'd1, 0, -1, 0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule